// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of a two-wire PHY management link. It reads and writes the 16-bit registers of an external PHY. The host starts an operation with a single-cycle `start` pulse. The pulse carries the direction, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The block then produces the whole serial transaction on `mdc`, with `mdio_o` and `mdio_oe` driving the tri-state pad and `mdio_i` returning the pad level.

Every transaction opens with a preamble of 32 high bits. A write then sends one 32-bit word and releases the line. A read sends only the 14 header bits and releases the line for one clock. During that clock it checks that the PHY pulled the line low, then shifts in 16 data bits and releases the line for one more clock. When the transaction ends, a one-cycle `done` pulse presents the read word and the acknowledge flag. A read without acknowledge reports all ones.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no transaction is running, `mdc`, `mdio_oe`, `busy` and `done` are all low.
- R2: A transaction begins, in the cycle after `start` is accepted, with 32 bit slots in which `mdio_oe` and `mdio_o` are both high.
- R3: Each bit slot holds `mdc` low for HALF_DIV cycles and then high for HALF_DIV cycles. `mdio_oe` and `mdio_o` change only at the start of a slot's low half.
- R4: A write (`op_write`=1) drives 32 frame slots, most significant bit first. The word is {2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wr_data}, so the PHY address sits in bits 27:23 and the register address in bits 22:18.
- R5: A read (`op_write`=0) drives only 14 frame slots, most significant bit first: {2'b01, 2'b10, phy_addr, reg_addr}.
- R6: After the 14 header bits of a read comes one released slot (`mdio_oe` low). The `mdio_i` level in the last cycle of its high half is the acknowledge: low means acknowledged, high means not acknowledged.
- R7: A read then has 16 released slots. In each, `mdio_i` is sampled in the last cycle of the high half, and the bits are assembled most significant bit first.
- R8: Every transaction ends with one released slot. In the next cycle `done` is high for exactly one cycle, `busy` is low, and `mdc` and `mdio_oe` are low. A read takes 64 slots in total and a write takes 65.
- R9: At `done`, an acknowledged read gives `ack`=1 and `rd_data` equal to the captured bits. An unacknowledged read gives `ack`=0 and `rd_data`=16'hFFFF. A write gives `ack`=0 and `rd_data`=0.
- R10: A `start` pulse while `busy` is high is ignored. The running transaction continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request; accepted only when idle |
| op_write | input | 1 | 1 = register write, 0 = register read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| ack | output | 1 | PHY acknowledge of a read, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Level driven onto the data line |
| mdio_oe | output | 1 | Output enable of the data-line driver |
| mdio_i | input | 1 | Level read from the data line |

## Verification
The bench compares `mdc`, `mdio_oe` and `mdio_o` every cycle against a schedule built from the requirements.

A wrong slot index or half-phase flag therefore appears at the pins within one MDC half-period. It shows either as a misplaced edge or as a driven bit in the wrong slot.

A fault in sampling or in the acknowledge logic stays hidden until the `done` cycle. There it shows as a wrong `rd_data` or `ack`, so the bench makes the PHY model return patterns that tell a bit-order error apart from a missing acknowledge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int SLOT_W       = 7;
  localparam int PRE_SLOTS    = 32;
  localparam int HDR_SLOTS    = 14;
  localparam int WORD_BITS    = 32;
  localparam int DATA_BITS    = 16;

  // slot numbers counted from the first preamble bit
  localparam logic [SLOT_W-1:0] FRAME_FIRST = SLOT_W'(PRE_SLOTS);
  localparam logic [SLOT_W-1:0] RD_ACK_SLOT = SLOT_W'(PRE_SLOTS + HDR_SLOTS);
  localparam logic [SLOT_W-1:0] RD_DAT_LO   = SLOT_W'(PRE_SLOTS + HDR_SLOTS + 1);
  localparam logic [SLOT_W-1:0] RD_DAT_HI   = SLOT_W'(PRE_SLOTS + HDR_SLOTS + DATA_BITS);
  localparam logic [SLOT_W-1:0] WR_LAST_DRV = SLOT_W'(PRE_SLOTS + WORD_BITS - 1);

  // serial word: start 01, opcode, phy[27:23], reg[22:18], turnaround 10, data
  function automatic logic [WORD_BITS-1:0] build_word(
    input logic             wr,
    input logic [4:0]       phy,
    input logic [4:0]       rg,
    input logic [DATA_BITS-1:0] dat
  );
    return {2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10,
            (wr ? dat : {DATA_BITS{1'b0}})};
  endfunction

  // index of the final slot of a transaction
  function automatic logic [SLOT_W-1:0] final_slot(input logic wr);
    return wr ? SLOT_W'(PRE_SLOTS + WORD_BITS) : SLOT_W'(PRE_SLOTS + HDR_SLOTS + DATA_BITS + 1);
  endfunction

  // is the line driven by the master in this slot
  function automatic logic slot_driven(input logic wr, input logic [SLOT_W-1:0] s);
    if (wr) return (s <= WR_LAST_DRV);
    return (s < RD_ACK_SLOT);
  endfunction

  // level driven in this slot (preamble high, then word MSB first)
  function automatic logic slot_level(input logic [WORD_BITS-1:0] w,
                                      input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] idx;
    if (s < FRAME_FIRST) return 1'b1;
    idx = WR_LAST_DRV - s;
    return w[idx[4:0]];
  endfunction

endpackage

// File: rtl/mdio_halfdiv.sv
module mdio_halfdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_DIV == 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;
      assign tick = run && (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        start,
  input  logic        op_write,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        ack,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                 busy_q, half_q, wr_q, ack_seen_q, done_q, ack_out_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [WORD_BITS-1:0] word_q;
  logic [DATA_BITS-1:0] shift_q, rd_q;

  // named internal events
  logic accept, half_end, last_slot, in_ack_slot, in_data_slot;
  assign accept       = start && !busy_q;
  assign half_end     = busy_q && tick && half_q;
  assign last_slot    = (slot_q == final_slot(wr_q));
  assign in_ack_slot  = !wr_q && (slot_q == RD_ACK_SLOT);
  assign in_data_slot = !wr_q && (slot_q >= RD_DAT_LO) && (slot_q <= RD_DAT_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      half_q     <= 1'b0;
      wr_q       <= 1'b0;
      ack_seen_q <= 1'b0;
      done_q     <= 1'b0;
      ack_out_q  <= 1'b0;
      slot_q     <= '0;
      word_q     <= '0;
      shift_q    <= '0;
      rd_q       <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        half_q     <= 1'b0;
        slot_q     <= '0;
        wr_q       <= op_write;
        word_q     <= build_word(op_write, phy_addr, reg_addr, wr_data);
        ack_seen_q <= 1'b0;
        shift_q    <= '0;
      end else if (busy_q && tick) begin
        if (!half_q) begin
          half_q <= 1'b1;
        end else begin
          half_q <= 1'b0;
          if (in_ack_slot)  ack_seen_q <= !mdio_i;
          if (in_data_slot) shift_q    <= {shift_q[DATA_BITS-2:0], mdio_i};
          if (last_slot) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b1;
            rd_q      <= wr_q ? '0 : (ack_seen_q ? shift_q : '1);
            ack_out_q <= !wr_q && ack_seen_q;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end
    end
  end

  logic drive_w;
  assign drive_w = busy_q && slot_driven(wr_q, slot_q);
  assign mdc     = busy_q && half_q;
  assign mdio_oe = drive_w;
  assign mdio_o  = drive_w && slot_level(word_q, slot_q);
  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;
  assign ack     = ack_out_q;

  // R1: divider stays parked while idle
  p_div_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !tick);
  // R2: first slot is a driven high preamble bit
  p_pre_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (mdio_oe && mdio_o));
  // R3: line is stable while MDC is high
  p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mdc && $past(mdc)) |-> ($stable(mdio_oe) && $stable(mdio_o)));
  // R8: line was released just before completion
  p_released_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!$past(mdio_oe) && !busy_q));
  // R8: completion pulse lasts one cycle
  p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: missing acknowledge reports all ones
  p_nack_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_q && !ack_out_q) |-> (rd_q == 16'hFFFF));
  // R10: a request while busy leaves the captured frame alone
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(word_q) && $stable(wr_q)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_write,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        ack,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic tick_w;

  mdio_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick_w)
  );

  mdio_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .start   (start),
    .op_write(op_write),
    .phy_addr(phy_addr),
    .reg_addr(reg_addr),
    .wr_data (wr_data),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .ack     (ack),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int HD = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, op_write = 1'b0, mdio_i = 1'b1;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy, done, ack, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  mdio_master #(.HALF_DIV(HD)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .ack(ack),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  // expected per-cycle pin schedule: {mdc, oe, o, pin level from PHY}
  typedef struct packed { logic mdc; logic oe; logic o; logic pin; } cyc_t;
  cyc_t sched[$];

  task automatic add_slot(input logic oe, input logic o, input logic pin);
    for (int k = 0; k < HD; k++) sched.push_back('{1'b0, oe, o, pin});
    for (int k = 0; k < HD; k++) sched.push_back('{1'b1, oe, o, pin});
  endtask

  task automatic run_op(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input bit phy_ack,
                        input logic [15:0] phy_d, input bit poke, input string tag);
    int bad = 0, first_bad = -1;
    logic [31:0] exp_rd;
    sched.delete();
    for (int i = 0; i < 32; i++) add_slot(1'b1, 1'b1, 1'b1);           // R2
    if (wr) begin
      logic [31:0] w = {2'b01, 2'b01, pa, ra, 2'b10, wd};               // R4
      for (int i = 31; i >= 0; i--) add_slot(1'b1, w[i], 1'b1);
      add_slot(1'b0, 1'b0, 1'b1);                                        // R8
    end else begin
      logic [13:0] h = {2'b01, 2'b10, pa, ra};                           // R5
      for (int i = 13; i >= 0; i--) add_slot(1'b1, h[i], 1'b1);
      add_slot(1'b0, 1'b0, phy_ack ? 1'b0 : 1'b1);                       // R6
      for (int i = 15; i >= 0; i--) add_slot(1'b0, 1'b0, phy_d[i]);      // R7
      add_slot(1'b0, 1'b0, 1'b1);                                        // R8
    end
    check(sched.size() == (wr ? 65 : 64) * 2 * HD, "R8", {tag, " slot count"},
          sched.size(), (wr ? 65 : 64) * 2 * HD);

    @(negedge clk);
    start = 1'b1; op_write = wr; phy_addr = pa; reg_addr = ra; wr_data = wd;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int idx = 0; idx < sched.size(); idx++) begin
      cyc_t c = sched[idx];
      mdio_i = c.pin;
      if (poke && idx == 100) begin                                      // R10
        start = 1'b1; op_write = !wr; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
      end
      if (poke && idx == 101) start = 1'b0;
      if (mdc !== c.mdc || mdio_oe !== c.oe || (c.oe && mdio_o !== c.o) ||
          busy !== 1'b1 || done !== 1'b0) begin
        bad++;
        if (first_bad < 0) first_bad = idx;
      end
      @(posedge clk);
      @(negedge clk);
    end
    check(bad == 0, wr ? "R2 R3 R4 R10" : "R2 R3 R5 R6 R7 R10",
          {tag, " waveform mismatching cycles (first index in upper half)"},
          {first_bad[15:0], bad[15:0]}, 32'h0);
    mdio_i = 1'b1;
    exp_rd = wr ? 32'h0 : (phy_ack ? {16'h0, phy_d} : 32'hFFFF);
    check(done === 1'b1 && busy === 1'b0, "R8", {tag, " done/busy at end"},
          {done, busy}, 2'b10);
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R8", {tag, " line parked"},
          {mdc, mdio_oe}, 2'b00);
    check(rd_data === exp_rd[15:0], "R9", {tag, " rd_data"}, rd_data, exp_rd);
    check(ack === (!wr && phy_ack), "R9", {tag, " ack"}, ack, (!wr && phy_ack));
    @(posedge clk);
    @(negedge clk);
    check(done === 1'b0, "R8", {tag, " done single cycle"}, done, 0);
    check(busy === 1'b0 && mdio_oe === 1'b0, "R1", {tag, " idle after"},
          {busy, mdio_oe}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mdc === 1'b0 && mdio_oe === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1", "reset state", {mdc, mdio_oe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(mdc === 1'b0 && mdio_oe === 1'b0 && busy === 1'b0, "R1", "idle out of reset",
          {mdc, mdio_oe, busy}, 0);

    run_op(1'b1, 5'h1A, 5'h05, 16'hA5C3, 1'b0, 16'h0000, 1'b0, "write a");
    run_op(1'b0, 5'h03, 5'h11, 16'h0000, 1'b1, 16'h1234, 1'b0, "read ack");
    run_op(1'b0, 5'h03, 5'h11, 16'h0000, 1'b0, 16'h1234, 1'b0, "read nack");
    run_op(1'b0, 5'h00, 5'h1F, 16'h0000, 1'b1, 16'h8001, 1'b0, "read edges");
    run_op(1'b0, 5'h1F, 5'h00, 16'h0000, 1'b1, 16'h0000, 1'b0, "read zero");
    run_op(1'b1, 5'h15, 5'h0A, 16'h00FF, 1'b0, 16'h0000, 1'b1, "write poked");
    run_op(1'b0, 5'h0C, 5'h13, 16'h0000, 1'b1, 16'hC3A5, 1'b1, "read poked");
    summary();
  end
endmodule